// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Boot Warm-Up

This block decides when a DRAM refresh is due and asks a memory controller for it over a request/acknowledge handshake. Its timing comes from single-cycle tick pulses derived from a separate I/O clock, not from the system clock it is clocked by. If no ticks arrive, no refresh is ever requested.

After reset the scheduler runs in a warm-up mode. In this mode refreshes come due eight times faster than normal, so that the few refreshes the memory needs before it works are finished quickly. While warm-up runs, a busy status stays high so that a "please wait" indication can be shown. Once the set number of refreshes has been acknowledged, the busy status drops and a fan-enable output rises. The interval timer then restarts at the normal rate. One cycle later a memory-ready output tells the boot logic that the memory test may begin.

Top module: `refresh_sched`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rfsh_req`, `fan_en` and `mem_ready` are 0 and `warm_busy` is 1.
- R2: During warm-up a refresh comes due on every FAST_TICKS-th sampled `io_tick`, where FAST_TICKS = NORM_TICKS/8. Ticks are counted without a break from reset, whatever the handshake is doing.
- R3: `rfsh_req` stays high until a cycle with `rfsh_ack` high. A due that arrives while a request is outstanding is kept as one pending flag, so `rfsh_req` stays high after that acknowledge. Any further dues arriving while the flag is set are dropped.
- R4: `warm_busy` stays 1 and `fan_en` stays 0 until WARM_COUNT (default 8) acknowledges have been accepted. Both outputs change at the clock edge that accepts the last of those acknowledges, and `fan_en` then remains 1.
- R5: `mem_ready` rises exactly one cycle after `fan_en` rises and then remains 1.
- R6: At the warm-up changeover the tick counter restarts. The next refresh comes due on the NORM_TICKS-th tick after the changeover, and every NORM_TICKS ticks after that.
- R7: `rfsh_req` rises only at a clock edge where `io_tick` is sampled high. With no ticks, no request is made and `mem_ready` stays 0.
- R8: An `rfsh_ack` while `rfsh_req` is 0 has no effect. The next request appears on schedule and is held as usual.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_tick | input | 1 | One-cycle pulse for each I/O clock period, already synchronized to `clk` |
| rfsh_ack | input | 1 | Controller has taken the current refresh request |
| rfsh_req | output | 1 | A refresh is requested; held until acknowledged |
| warm_busy | output | 1 | Warm-up refreshes are in progress |
| fan_en | output | 1 | Warm-up finished; enables the fans |
| mem_ready | output | 1 | Normal refresh rate in force; memory may be tested |

## Verification
The properties assume that `io_tick` and `rfsh_ack` are single-cycle pulses synchronous to `clk`, and that an acknowledge given while no request is outstanding is harmless rather than forbidden. The stimulus applies one tick every four cycles, so a request is always acknowledged before the next tick arrives, except in the phase that deliberately withholds the acknowledge. The stimulus also inserts a stray acknowledge and a long tick-free stretch, to exercise the ignore and no-clock cases at the ports.

// File: rtl/refsch_pkg.sv
package refsch_pkg;
  typedef enum logic {
    RATE_FAST = 1'b0,
    RATE_NORM = 1'b1
  } refsch_rate_t;

  typedef enum logic [1:0] {
    OWE_NONE = 2'd0,
    OWE_ONE  = 2'd1,
    OWE_TWO  = 2'd2
  } refsch_owed_t;
endpackage

// File: rtl/refsch_interval.sv
module refsch_interval
  import refsch_pkg::*;
#(
  parameter int NORM_TICKS = 64,
  parameter int FAST_TICKS = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         io_tick,
  input  refsch_rate_t rate,
  input  logic         restart,
  output logic         due
);
  localparam int CW = (NORM_TICKS > 1) ? $clog2(NORM_TICKS) : 1;
  localparam logic [CW-1:0] NORM_LAST = CW'(NORM_TICKS - 1);
  localparam logic [CW-1:0] FAST_LAST = CW'(FAST_TICKS - 1);

  logic [CW-1:0] ticks_q;
  logic [CW-1:0] last;

  assign last = (rate == RATE_NORM) ? NORM_LAST : FAST_LAST;
  assign due  = io_tick && (ticks_q >= last) && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      ticks_q <= '0;
    end else if (io_tick) begin
      if (ticks_q >= last) ticks_q <= '0;
      else                 ticks_q <= ticks_q + 1'b1;
    end
  end
endmodule

// File: rtl/refsch_backlog.sv
module refsch_backlog
  import refsch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic due,
  input  logic ack,
  output logic req,
  output logic taken
);
  refsch_owed_t owed_q, owed_nx;

  assign taken = ack && (owed_q != OWE_NONE);

  always_comb begin
    owed_nx = owed_q;
    case (owed_q)
      OWE_NONE: owed_nx = due ? OWE_ONE : OWE_NONE;
      OWE_ONE:  begin
        if (taken && !due)      owed_nx = OWE_NONE;
        else if (!taken && due) owed_nx = OWE_TWO;
        else                    owed_nx = OWE_ONE;
      end
      default:  owed_nx = (taken && !due) ? OWE_ONE : OWE_TWO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q <= OWE_NONE;
      req    <= 1'b0;
    end else begin
      owed_q <= owed_nx;
      req    <= (owed_nx != OWE_NONE);
    end
  end
endmodule

// File: rtl/refsch_warmup.sv
module refsch_warmup #(
  parameter int WARM_COUNT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic taken,
  output logic finish,
  output logic busy,
  output logic fan,
  output logic ready
);
  localparam int WW = $clog2(WARM_COUNT + 1);
  localparam logic [WW-1:0] WLAST = WW'(WARM_COUNT - 1);

  logic [WW-1:0] done_cnt_q;

  assign finish = taken && busy && (done_cnt_q == WLAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_cnt_q <= '0;
      busy       <= 1'b1;
      fan        <= 1'b0;
      ready      <= 1'b0;
    end else begin
      if (taken && busy) done_cnt_q <= done_cnt_q + 1'b1;
      if (finish) begin
        busy <= 1'b0;
        fan  <= 1'b1;
      end
      ready <= fan;
    end
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsch_pkg::*;
#(
  parameter int NORM_TICKS = 64,
  parameter int FAST_DIV   = 8,
  parameter int WARM_COUNT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic io_tick,
  input  logic rfsh_ack,
  output logic rfsh_req,
  output logic warm_busy,
  output logic fan_en,
  output logic mem_ready
);
  localparam int FAST_TICKS = (NORM_TICKS / FAST_DIV > 0) ? NORM_TICKS / FAST_DIV : 1;

  logic         due;
  logic         taken;
  logic         finish;
  refsch_rate_t rate;

  assign rate = fan_en ? RATE_NORM : RATE_FAST;

  refsch_interval #(
    .NORM_TICKS(NORM_TICKS),
    .FAST_TICKS(FAST_TICKS)
  ) u_interval (
    .clk     (clk),
    .rst     (rst),
    .io_tick (io_tick),
    .rate    (rate),
    .restart (finish),
    .due     (due)
  );

  refsch_backlog u_backlog (
    .clk   (clk),
    .rst   (rst),
    .due   (due),
    .ack   (rfsh_ack),
    .req   (rfsh_req),
    .taken (taken)
  );

  refsch_warmup #(
    .WARM_COUNT(WARM_COUNT)
  ) u_warmup (
    .clk    (clk),
    .rst    (rst),
    .taken  (taken),
    .finish (finish),
    .busy   (warm_busy),
    .fan    (fan_en),
    .ready  (mem_ready)
  );
endmodule

// File: rtl/refsch_chk.sv
module refsch_chk (
  input logic clk,
  input logic rst,
  input logic io_tick,
  input logic rfsh_ack,
  input logic rfsh_req,
  input logic warm_busy,
  input logic fan_en,
  input logic mem_ready
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (rfsh_req && !rfsh_ack) |=> rfsh_req);

  p_fan_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    fan_en |=> fan_en);

  p_fan_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(fan_en) |-> $past(rfsh_req && rfsh_ack));

  p_ready_after_fan_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ready) |-> $past(fan_en));

  p_ready_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    mem_ready |=> mem_ready);

  p_req_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rfsh_req) |-> $past(io_tick));

  always @(posedge clk) begin
    if (!rst) begin
      p_busy_vs_fan_r4: assert (warm_busy != fan_en);
    end
  end
endmodule

bind refresh_sched refsch_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .io_tick   (io_tick),
  .rfsh_ack  (rfsh_ack),
  .rfsh_req  (rfsh_req),
  .warm_busy (warm_busy),
  .fan_en    (fan_en),
  .mem_ready (mem_ready)
);

// File: tb/sim_refresh_sched.sv
`timescale 1ns/1ps
module sim_refresh_sched;
  localparam int NORM = 32;
  localparam int FAST = NORM / 8;
  localparam int WARM = 8;
  localparam real HALF = 4.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_tick = 1'b0;
  logic ack_auto = 1'b0;
  logic ack_man = 1'b0;
  logic rfsh_ack;
  logic rfsh_req, warm_busy, fan_en, mem_ready;

  assign rfsh_ack = ack_auto | ack_man;

  refresh_sched #(.NORM_TICKS(NORM), .FAST_DIV(8), .WARM_COUNT(WARM)) u0 (
    .clk(clk), .rst(rst), .io_tick(io_tick), .rfsh_ack(rfsh_ack),
    .rfsh_req(rfsh_req), .warm_busy(warm_busy), .fan_en(fan_en),
    .mem_ready(mem_ready)
  );

  always #(HALF) clk = ~clk;

  int nchk = 0;
  int nbad = 0;
  int tick_no = 0;
  int acks = 0;
  bit auto_on = 1'b0;
  bit sb_on = 1'b0;
  bit done = 1'b0;
  int exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  endtask

  always @(posedge clk) if (io_tick) tick_no <= tick_no + 1;

  // monitor: pops expected tick numbers, answers requests in auto mode
  logic req_prev = 1'b0;
  logic ack_prev = 1'b0;
  bit   want_ready = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (want_ready) begin
        check(mem_ready == 1'b1, "R5 ready one cycle after fan", mem_ready, 1);
        want_ready = 1'b0;
      end
      if (ack_prev && rfsh_ack == 1'b1 && acks == WARM) begin
        check(fan_en == 1'b1, "R4 fan at last warm ack", fan_en, 1);
        check(warm_busy == 1'b0, "R4 busy drops at last warm ack", warm_busy, 0);
        check(mem_ready == 1'b0, "R5 ready not yet", mem_ready, 0);
        want_ready = 1'b1;
      end
      if (rfsh_req && !req_prev && sb_on) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2/R6 unexpected request", tick_no, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(tick_no == e, (e <= WARM*FAST) ? "R2 fast due tick" : "R6 normal due tick",
                tick_no, e);
        end
        if (acks < WARM) begin
          check(fan_en == 1'b0 && warm_busy == 1'b1, "R4 still warming", fan_en, 0);
        end
      end
      ack_prev = 1'b0;
      if (auto_on && rfsh_req && !ack_auto) begin
        ack_auto <= 1'b1;
        acks = acks + 1;
        ack_prev = 1'b1;
      end else begin
        ack_auto <= 1'b0;
      end
      req_prev = rfsh_req;
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) io_tick = 1'b1;
      @(negedge clk) io_tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic man_ack();
    @(negedge clk) ack_man = 1'b1;
    @(negedge clk) ack_man = 1'b0;
  endtask

  initial begin
    #(HALF * 2 * 40000);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(rfsh_req == 0 && fan_en == 0 && mem_ready == 0, "R1 outputs low in reset", rfsh_req, 0);
    check(warm_busy == 1'b1, "R1 busy in reset", warm_busy, 1);
    @(negedge clk) rst = 1'b0;
    check(rfsh_req == 0 && warm_busy == 1 && fan_en == 0, "R1 after reset", rfsh_req, 0);

    // no ticks: nothing happens
    repeat (60) @(negedge clk);
    check(rfsh_req == 1'b0, "R7 no request without ticks", rfsh_req, 0);
    check(mem_ready == 1'b0, "R7 not ready without ticks", mem_ready, 0);

    // warm-up then normal rate, driver pushes the expected due ticks
    for (int k = 1; k <= WARM; k++) exp_q.push_back(k * FAST);
    for (int k = 1; k <= 3; k++) exp_q.push_back(WARM * FAST + k * NORM);
    auto_on = 1'b1;
    sb_on = 1'b1;
    ticks(WARM * FAST + 3 * NORM);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R6 all dues seen", exp_q.size(), 0);
    check(fan_en == 1'b1 && mem_ready == 1'b1, "R5 ready held", mem_ready, 1);
    check(rfsh_req == 1'b0, "R3 request cleared by ack", rfsh_req, 0);

    // withhold acknowledges: three dues, only one pending kept
    auto_on = 1'b0;
    sb_on = 1'b0;
    ticks(NORM - 1);
    check(rfsh_req == 1'b0, "R6 not due one tick early", rfsh_req, 0);
    ticks(1);
    check(rfsh_req == 1'b1, "R6 due on schedule", rfsh_req, 1);
    ticks(2 * NORM);
    check(rfsh_req == 1'b1, "R3 request held without ack", rfsh_req, 1);
    man_ack();
    check(rfsh_req == 1'b1, "R3 pending due kept", rfsh_req, 1);
    man_ack();
    check(rfsh_req == 1'b0, "R3 only one pending kept", rfsh_req, 0);

    // stray acknowledge ignored
    man_ack();
    check(rfsh_req == 1'b0, "R8 stray ack no effect", rfsh_req, 0);
    ticks(NORM - 1);
    check(rfsh_req == 1'b0, "R8 schedule unchanged early", rfsh_req, 0);
    ticks(1);
    check(rfsh_req == 1'b1, "R8 next due on schedule", rfsh_req, 1);
    repeat (3) @(negedge clk);
    check(rfsh_req == 1'b1, "R8 request still held", rfsh_req, 1);
    man_ack();
    check(rfsh_req == 1'b0, "R3 ack clears single request", rfsh_req, 0);
    check(fan_en == 1 && mem_ready == 1 && warm_busy == 0, "R4 R5 status stable", mem_ready, 1);
    finish_run();
  end
endmodule